// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product C = A·B·R⁻¹ mod P. Here R = 2^(32·W), and W is the operand length in 32-bit words. The three operands live in a shared single-port scratch RAM of 32-bit words, and each one is found through its own 9-bit word pointer. The result goes back into the same RAM at a fourth pointer. All accesses share the one RAM port. That port has a registered address and one cycle of read latency.

For each word of A, the engine computes a per-word reduction factor. It uses a 32-bit constant q, equal to −P⁻¹ mod 2^32. It then adds A[i]·B + m·P into an internal accumulator that is one word wider than the operand, and shifts the accumulator down by one word. After the last word it compares the accumulator with P. It writes out either the accumulator or the accumulator minus P, so the result lies in [0, P).

A controller starts the block with a rising edge on `start`, after placing operands and pointers. It then waits for `done`. A 6-bit length code sets the operand size, from 32 bits up to 2048 bits in 32-bit steps.

Top module: `mont_mul_ws`

## Requirements
- R1: After an operation, RAM words ptr_c+k for k = 0..W−1 hold C = A·B·2^(−32W) mod P, least significant word first. A, B and P are read little-endian from ptr_a, ptr_b and ptr_p. The conditions are P odd and A, B < P.
- R2: Length code L gives W = L+1 words (0x07 = 256 bits, 0x08 = 288 bits, 0x3F = 2048 bits). Exactly W result words are written, and the RAM word at ptr_c+W is left unchanged.
- R3: Each of the four pointers is an independent 9-bit word address. Word k of an operand is at (pointer + k) mod 512, so a result block may wrap past address 0x1FF to 0x000.
- R4: The reduction uses the constant `mont_q`, sampled at the start edge. For a modulus whose low word is 0xFFFFFFFF, a constant of 1 gives the correct product.
- R5: An operation begins only on a 0-to-1 transition of `start` while idle. Holding `start` high starts nothing further, and a new 0-to-1 transition while busy is ignored (it produces no second `done`).
- R6: `busy` rises on the clock edge that samples the start transition. It stays high until the edge after the last result write is issued. At that edge `busy` falls and `done` is high for exactly one cycle.
- R7: The result is always fully reduced (C < P). This holds when the accumulator ends at or above P, for example with A = B = P−1.
- R8: After synchronous reset, `busy`, `done` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, acted on at its rising edge |
| len_code | input | 6 | Operand length code, W = len_code + 1 words |
| mont_q | input | 32 | Montgomery constant −P⁻¹ mod 2^32 |
| ptr_a | input | 9 | Word pointer of operand A |
| ptr_b | input | 9 | Word pointer of operand B |
| ptr_p | input | 9 | Word pointer of modulus P |
| ptr_c | input | 9 | Word pointer of result C |
| mem_addr | output | 9 | Scratch RAM word address (registered) |
| mem_we | output | 1 | Scratch RAM write enable (registered) |
| mem_wdata | output | 32 | Scratch RAM write data (registered) |
| mem_rdata | input | 32 | Scratch RAM read data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest path to reach from the ports is the final conditional subtraction. The accumulator only ends at or above P for some operand values, and random operands rarely lead there. The stimulus therefore adds directed operands next to the modulus: A = B = P−1, and a modulus with an all-ones low word. These are added to random odd moduli at 256 and 288 bits and one 2048-bit case. Each result is compared with a reference computed as (A·B mod P) followed by repeated modular halving. Pointer wrap and start-edge misuse are exercised by separate runs that move the result block across address 0 and that hold or re-pulse `start` during an operation.

// File: rtl/mmw_pkg.sv
package mmw_pkg;
  typedef enum logic [4:0] {
    ST_IDLE,
    ST_AA,   // issue A[i] address
    ST_AB,   // issue B[0] address
    ST_AW,   // capture A[i]
    ST_AM,   // B[0] on bus, form reduction factor
    ST_JB,   // issue B[j]
    ST_JP,   // issue P[j]
    ST_JW,   // capture B[j]
    ST_JM,   // P[j] on bus, multiply-accumulate
    ST_TOP,  // fold carry into top words
    ST_CB,   // compare pass: issue P[j]
    ST_CW,
    ST_CC,   // compare pass: borrow chain
    ST_WB,   // write pass: issue P[j]
    ST_WW,
    ST_WC,   // write pass: emit result word
    ST_FIN
  } mmw_state_e;
endpackage

// File: rtl/mmw_mac.sv
module mmw_mac #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] t_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] m_in,
  input  logic [DW-1:0] p_in,
  input  logic [DW+1:0] c_in,
  output logic [DW-1:0] lo_out,
  output logic [DW+1:0] c_out
);
  localparam int SW = 2*DW + 2;
  logic [SW-1:0] ab, mp, sum;

  always_comb begin
    ab  = {{(DW+2){1'b0}}, a_in} * {{(DW+2){1'b0}}, b_in};
    mp  = {{(DW+2){1'b0}}, m_in} * {{(DW+2){1'b0}}, p_in};
    sum = ab + mp + {{(DW+2){1'b0}}, t_in} + {{DW{1'b0}}, c_in};
    lo_out = sum[DW-1:0];
    c_out  = sum[SW-1:DW];
  end
endmodule

// File: rtl/mmw_tbuf.sv
module mmw_tbuf #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mont_mul_ws.sv
module mont_mul_ws
  import mmw_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 9,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len_code,
  input  logic [DW-1:0] mont_q,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  input  logic [AW-1:0] ptr_p,
  input  logic [AW-1:0] ptr_c,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done
);
  localparam int IW = LW + 1;

  mmw_state_e    state;
  logic          start_d;
  logic [LW-1:0] len_q;
  logic [DW-1:0] q_q;
  logic [AW-1:0] pa_q, pb_q, pp_q, pc_q;
  logic [IW-1:0] i_q, j_q;
  logic [DW-1:0] ai_q, bj_q, m_q, ttop_q;
  logic [DW+1:0] cy_q;
  logic          first_q, br_q, ge_q;

  logic [IW-1:0] last_idx;
  logic          go;
  logic [DW-1:0] trd, tval, ttop_eff, mlo, m_next, mac_lo;
  logic [DW+1:0] mac_cy, top_sum;
  logic [DW:0]   diff;
  logic          twe;
  logic [LW-1:0] twaddr;
  logic [DW-1:0] twdata;

  assign last_idx = {1'b0, len_q};
  assign go       = start & ~start_d & (state == ST_IDLE);
  assign tval     = first_q ? '0 : trd;
  assign ttop_eff = first_q ? '0 : ttop_q;
  assign mlo      = tval + ai_q * mem_rdata;
  assign m_next   = mlo * q_q;
  assign top_sum  = {2'b00, ttop_eff} + cy_q;
  assign diff     = {1'b0, trd} - {1'b0, mem_rdata} - {{DW{1'b0}}, br_q};

  always_comb begin
    twe    = 1'b0;
    twaddr = LW'(j_q - IW'(1));
    twdata = mac_lo;
    if (state == ST_JM && j_q != '0) begin
      twe = 1'b1;
    end else if (state == ST_TOP) begin
      twe    = 1'b1;
      twaddr = len_q;
      twdata = top_sum[DW-1:0];
    end
  end

  mmw_tbuf #(.DW(DW), .AW(LW)) u_tbuf (
    .clk   (clk),
    .we    (twe),
    .waddr (twaddr),
    .wdata (twdata),
    .raddr (j_q[LW-1:0]),
    .rdata (trd)
  );

  mmw_mac #(.DW(DW)) u_mac (
    .t_in   (tval),
    .a_in   (ai_q),
    .b_in   (bj_q),
    .m_in   (m_q),
    .p_in   (mem_rdata),
    .c_in   (cy_q),
    .lo_out (mac_lo),
    .c_out  (mac_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      start_d   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      i_q       <= '0;
      j_q       <= '0;
      first_q   <= 1'b1;
      br_q      <= 1'b0;
      ge_q      <= 1'b0;
    end else begin
      start_d <= start;
      done    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          mem_we <= 1'b0;
          if (go) begin
            len_q   <= len_code;
            q_q     <= mont_q;
            pa_q    <= ptr_a;
            pb_q    <= ptr_b;
            pp_q    <= ptr_p;
            pc_q    <= ptr_c;
            i_q     <= '0;
            j_q     <= '0;
            first_q <= 1'b1;
            busy    <= 1'b1;
            state   <= ST_AA;
          end
        end
        ST_AA: begin
          mem_addr <= pa_q + AW'(i_q);
          j_q      <= '0;
          state    <= ST_AB;
        end
        ST_AB: begin
          mem_addr <= pb_q;
          state    <= ST_AW;
        end
        ST_AW: begin
          ai_q  <= mem_rdata;
          state <= ST_AM;
        end
        ST_AM: begin
          m_q   <= m_next;
          cy_q  <= '0;
          state <= ST_JB;
        end
        ST_JB: begin
          mem_addr <= pb_q + AW'(j_q);
          state    <= ST_JP;
        end
        ST_JP: begin
          mem_addr <= pp_q + AW'(j_q);
          state    <= ST_JW;
        end
        ST_JW: begin
          bj_q  <= mem_rdata;
          state <= ST_JM;
        end
        ST_JM: begin
          cy_q <= mac_cy;
          if (j_q == last_idx) begin
            state <= ST_TOP;
          end else begin
            j_q   <= j_q + IW'(1);
            state <= ST_JB;
          end
        end
        ST_TOP: begin
          ttop_q  <= {{(DW-2){1'b0}}, top_sum[DW+1:DW]};
          first_q <= 1'b0;
          if (i_q == last_idx) begin
            j_q   <= '0;
            br_q  <= 1'b0;
            state <= ST_CB;
          end else begin
            i_q   <= i_q + IW'(1);
            state <= ST_AA;
          end
        end
        ST_CB: begin
          mem_addr <= pp_q + AW'(j_q);
          state    <= ST_CW;
        end
        ST_CW: state <= ST_CC;
        ST_CC: begin
          if (j_q == last_idx) begin
            ge_q  <= (ttop_q != '0) || !diff[DW];
            br_q  <= 1'b0;
            j_q   <= '0;
            state <= ST_WB;
          end else begin
            br_q  <= diff[DW];
            j_q   <= j_q + IW'(1);
            state <= ST_CB;
          end
        end
        ST_WB: begin
          mem_we   <= 1'b0;
          mem_addr <= pp_q + AW'(j_q);
          state    <= ST_WW;
        end
        ST_WW: state <= ST_WC;
        ST_WC: begin
          mem_wdata <= ge_q ? diff[DW-1:0] : trd;
          mem_addr  <= pc_q + AW'(j_q);
          mem_we    <= 1'b1;
          br_q      <= diff[DW];
          if (j_q == last_idx) begin
            state <= ST_FIN;
          end else begin
            j_q   <= j_q + IW'(1);
            state <= ST_WB;
          end
        end
        ST_FIN: begin
          mem_we <= 1'b0;
          busy   <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmw_chk.sv
module mmw_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic mem_we
);
  // R6: done only appears once the block is idle again
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: busy never drops without the completion pulse
  a_r6_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R5: an operation begins only after start was seen high
  a_r5_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R2: RAM writes happen only inside an operation
  a_r2_write_in_op: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R8: idle block leaves the RAM alone
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> !mem_we);
endmodule

bind mont_mul_ws mmw_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .mem_we (mem_we)
);

// File: tb/sim_mont_mul_ws.sv
`timescale 1ns/1ps
module sim_mont_mul_ws;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  len_code = 6'd7;
  logic [31:0] mont_q = 32'd1;
  logic [8:0]  ptr_a = 9'h000, ptr_b = 9'h008, ptr_p = 9'h010, ptr_c = 9'h018;
  logic [8:0]  mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        busy, done;

  logic [31:0] ram [512];
  logic        ld_we = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  int checks = 0;
  int errors = 0;
  int ndone  = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    else if (ld_we) ram[ld_addr] <= ld_data;
    mem_rdata <= ram[mem_addr];
  end

  always @(negedge clk) if (done) ndone++;

  mont_mul_ws u0 (
    .clk(clk), .rst(rst), .start(start), .len_code(len_code), .mont_q(mont_q),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_p(ptr_p), .ptr_c(ptr_c),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [2047:0] act, input logic [2047:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic logic [2047:0] mref(input logic [2047:0] a, input logic [2047:0] b,
                                         input logic [2047:0] p, input int w);
    logic [4095:0] x, pp;
    pp = {2048'b0, p};
    x  = ({2048'b0, a} * {2048'b0, b}) % pp;
    for (int k = 0; k < 32*w; k++) begin
      if (x[0]) x = (x + pp) >> 1;
      else      x = x >> 1;
    end
    return x[2047:0];
  endfunction

  function automatic logic [31:0] qconst(input logic [31:0] p0);
    logic [31:0] inv = p0;
    for (int k = 0; k < 5; k++) inv = inv * (32'd2 - p0 * inv);
    return -inv;
  endfunction

  function automatic logic [2047:0] rnd_mod(input int w);
    logic [2047:0] p = '0;
    for (int k = 0; k < w; k++) p[32*k +: 32] = $urandom;
    p[32*w-1] = 1'b1;
    p[0] = 1'b1;
    return p;
  endfunction

  function automatic logic [2047:0] rnd_below(input logic [2047:0] p, input int w);
    logic [2047:0] v = '0;
    for (int k = 0; k < w; k++) v[32*k +: 32] = $urandom;
    return v % p;
  endfunction

  // mode 0: plain pulse; 1: hold start high; 2: extra start edge while busy
  task automatic run(input string tag, input int w, input logic [2047:0] a,
                     input logic [2047:0] b, input logic [2047:0] p, input logic [31:0] q,
                     input logic [8:0] pa, input logic [8:0] pb, input logic [8:0] pp,
                     input logic [8:0] pc, input int mode);
    logic [2047:0] res, exp;
    logic [8:0] sent;
    int n0, cyc;
    for (int k = 0; k < w; k++) begin
      put(pa + 9'(k), a[32*k +: 32]);
      put(pb + 9'(k), b[32*k +: 32]);
      put(pp + 9'(k), p[32*k +: 32]);
    end
    sent = pc + 9'(w);
    put(sent, 32'hDEADBEEF);
    @(negedge clk);
    len_code = 6'(w - 1); mont_q = q;
    ptr_a = pa; ptr_b = pb; ptr_p = pp; ptr_c = pc;
    n0 = ndone;
    start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R6", {tag, " busy after start edge"}, 2048'(busy), 2048'd1);
    if (mode != 1) start = 1'b0;
    if (mode == 2) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R6", {tag, " done pulse with busy low"},
        2048'({done, busy}), 2048'(2'b10));
    @(negedge clk);
    chk(done == 1'b0, "R6", {tag, " done lasts one cycle"}, 2048'(done), 2048'd0);
    res = '0;
    for (int k = 0; k < w; k++) res[32*k +: 32] = ram[pc + 9'(k)];
    exp = mref(a, b, p, w);
    chk(res == exp, "R1", {tag, " product"}, res, exp);
    chk(res < p, "R7", {tag, " fully reduced"}, res, p);
    chk(ram[sent] == 32'hDEADBEEF, "R2", {tag, " word past result untouched"},
        2048'(ram[sent]), 2048'h0DEADBEEF);
    if (mode == 1) begin
      repeat (30) @(negedge clk);
      chk(busy == 1'b0, "R5", {tag, " held start does not restart"}, 2048'(busy), 2048'd0);
      start = 1'b0;
    end
    if (mode == 2) begin
      repeat (30) @(negedge clk);
      chk(ndone - n0 == 1 && busy == 1'b0, "R5", {tag, " start edge while busy ignored"},
          2048'(ndone - n0), 2048'd1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2047:0] p, a, b;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8", "reset busy", 2048'(busy), 2048'd0);
    chk(done == 1'b0, "R8", "reset done", 2048'(done), 2048'd0);
    chk(mem_we == 1'b0, "R8", "reset mem_we", 2048'(mem_we), 2048'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4: all-ones low word with constant 1
    p = rnd_mod(8); p[31:0] = 32'hFFFFFFFF;
    run("R4 q=1", 8, rnd_below(p, 8), rnd_below(p, 8), p, 32'd1,
        9'h000, 9'h008, 9'h010, 9'h018, 0);

    // R1/R2: random odd moduli at 256 bits (code 0x07) and 288 bits (code 0x08)
    for (int n = 0; n < 10; n++) begin
      p = rnd_mod(8);
      run("R1 256b", 8, rnd_below(p, 8), rnd_below(p, 8), p, qconst(p[31:0]),
          9'h000, 9'h008, 9'h010, 9'h018, 0);
    end
    for (int n = 0; n < 10; n++) begin
      p = rnd_mod(9);
      run("R1 288b", 9, rnd_below(p, 9), rnd_below(p, 9), p, qconst(p[31:0]),
          9'h020, 9'h040, 9'h060, 9'h080, 0);
    end

    // R7: operands next to the modulus, plus zero and one
    p = rnd_mod(8);
    run("R7 p-1 sq", 8, p - 1, p - 1, p, qconst(p[31:0]), 9'h000, 9'h008, 9'h010, 9'h018, 0);
    p = rnd_mod(9); p[32*9-1 -: 32] = 32'hFFFFFFFF;
    run("R7 p-1 big", 9, p - 1, p - 2, p, qconst(p[31:0]), 9'h000, 9'h010, 9'h020, 9'h030, 0);
    run("R1 zero", 9, '0, p - 1, p, qconst(p[31:0]), 9'h000, 9'h010, 9'h020, 9'h030, 0);
    run("R1 one", 9, 2048'd1, 2048'd1, p, qconst(p[31:0]), 9'h000, 9'h010, 9'h020, 9'h030, 0);

    // R3: result block wraps past the top of the RAM
    p = rnd_mod(9);
    run("R3 wrap", 9, rnd_below(p, 9), rnd_below(p, 9), p, qconst(p[31:0]),
        9'h100, 9'h120, 9'h140, 9'h1FC, 0);

    // R5: held start, and a second edge while busy
    p = rnd_mod(8);
    run("R5 hold", 8, rnd_below(p, 8), rnd_below(p, 8), p, qconst(p[31:0]),
        9'h000, 9'h008, 9'h010, 9'h018, 1);
    p = rnd_mod(8);
    run("R5 reedge", 8, rnd_below(p, 8), rnd_below(p, 8), p, qconst(p[31:0]),
        9'h000, 9'h008, 9'h010, 9'h018, 2);

    // R2: 2048-bit operand (code 0x3F)
    p = rnd_mod(64);
    a = rnd_below(p, 64);
    b = rnd_below(p, 64);
    run("R2 2048b", 64, a, b, p, qconst(p[31:0]), 9'h000, 9'h040, 9'h080, 9'h0C0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule